// File: doc/BRIEF.md
# Butterfly Destination Router

This block moves one message per port through a radix-2 butterfly built from `ADDR_W` columns of 2x2 switches serving `2**ADDR_W` ports. Each incoming message carries a destination port number and a payload. Every switch steers a message to its even or odd output using one bit of that destination, and fixed wiring between columns places the bit just decided into its final position. After the last column the message's position equals its destination, so the payload leaves on that output port.

Traffic can cross the switch columns in either order. With the direction input low, messages enter at column 0 and leave after the highest column. With it high, they enter at the highest column and leave after column 0. Each order uses its own table of which destination bit each column consults and which bits its links exchange. Each column ends in a register, so a message spends exactly `ADDR_W` cycles in the block, and a new set of messages can enter every cycle. The block does not arbitrate contention inside the network. The traffic source presents only sets of messages whose paths never ask for the same switch output in the same column.

Top module: `bfly_router`

## Requirements
- R1: While reset is asserted, and on the first cycles after its release, `out_vld` is all zeros.
- R2: A message presented with `in_vld[p]` high at a rising clock edge appears on the outputs exactly `ADDR_W` rising edges later, and at no other cycle.
- R3: With `dir_i` = 0 (forward), every message leaves on the output port whose number equals its `in_dst[p*ADDR_W +: ADDR_W]` field. Column k (k = 0 first) puts destination bit `ADDR_W-1-k` into the switch-local output bit (bit 0 of the position). Its link then exchanges position bits 0 and `ADDR_W-1-k`. Switches pair positions 2j and 2j+1.
- R4: With `dir_i` = 1 (reverse), messages cross column `ADDR_W-1` first and column 0 last, and each leaves on the port equal to its destination. A column numbered c >= 1 uses destination bit `ADDR_W-c`, and its link exchanges position bits 0 and `ADDR_W-c`. Column 0 uses destination bit 0 and has no exchange.
- R5: The payload at `out_pay[q*PAY_W +: PAY_W]` equals the payload that entered with the message that arrives at port q.
- R6: For any set of messages with no contention, each valid input yields exactly one valid output, and no output is valid without a matching input. Contention means two messages want the same switch output in the same column under the rules of R3 or R4.
- R7: The direction is taken from `dir_i` only while no message is inside the network, and it then applies to messages entering in that same cycle. While any message is in flight, changes on `dir_i` are ignored: messages entering then follow the direction already held.
- R8: A new set of messages may enter on every cycle, and back-to-back sets are delivered without loss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dir_i | input | 1 | Traversal order: 0 forward, 1 reverse |
| in_vld | input | 2**ADDR_W | Per-port message valid |
| in_dst | input | 2**ADDR_W*ADDR_W | Per-port destination, port p at bits [p*ADDR_W +: ADDR_W] |
| in_pay | input | 2**ADDR_W*PAY_W | Per-port payload, port p at bits [p*PAY_W +: PAY_W] |
| out_vld | output | 2**ADDR_W | Per-port delivery valid |
| out_pay | output | 2**ADDR_W*PAY_W | Per-port delivered payload |

## Verification
The hardest case to reach is the held direction. Every contention-free message reaches its destination in either order, so a wrong direction shows only as contention. The bench searches random permutations for sets that have no contention in one order but do in the other. It injects them right after a direction change while the network is empty, and again while earlier traffic is in flight with `dir_i` flipped. A message lost or duplicated in those sets shows that the wrong direction was used.

// File: rtl/bfly_pkg.sv
`timescale 1ns/1ps
package bfly_pkg;

  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } dir_e;

  // Bit position consulted by the switches of pipeline slot `slot`, and also
  // the position its link exchanges with bit 0 (0 means no exchange).
  // Slot 0 is the first column crossed; in reverse it is the highest column.
  function automatic int route_pos(input int aw, input int slot, input bit rev);
    if (!rev) return aw - 1 - slot;
    else if (slot < aw - 1) return slot + 1;
    else return 0;
  endfunction

  // Exchange bit 0 and bit `pos` of a port position.
  function automatic int swap_lsb(input int a, input int pos);
    int b0;
    int bp;
    int r;
    b0 = a & 1;
    bp = (a >> pos) & 1;
    r  = a & ~(1 | (1 << pos));
    return r | (b0 << pos) | bp;
  endfunction

endpackage

// File: rtl/bfly_rst_sync.sv
`timescale 1ns/1ps
module bfly_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/bfly_switch2.sv
`timescale 1ns/1ps
module bfly_switch2 #(
  parameter int ADDR_W = 3,
  parameter int PAY_W  = 16
) (
  input  logic              up_vld,
  input  logic [ADDR_W-1:0] up_dst,
  input  logic [PAY_W-1:0]  up_pay,
  input  logic              up_want,
  input  logic              lo_vld,
  input  logic [ADDR_W-1:0] lo_dst,
  input  logic [PAY_W-1:0]  lo_pay,
  input  logic              lo_want,
  output logic              o0_vld,
  output logic [ADDR_W-1:0] o0_dst,
  output logic [PAY_W-1:0]  o0_pay,
  output logic              o1_vld,
  output logic [ADDR_W-1:0] o1_dst,
  output logic [PAY_W-1:0]  o1_pay
);
  logic up_to0, up_to1, lo_to0, lo_to1;

  always_comb begin
    up_to0 = up_vld && !up_want;
    up_to1 = up_vld &&  up_want;
    lo_to0 = lo_vld && !lo_want;
    lo_to1 = lo_vld &&  lo_want;

    // even output: upper input has precedence if both ask for it
    o0_vld = up_to0 || lo_to0;
    o0_dst = up_to0 ? up_dst : lo_dst;
    o0_pay = up_to0 ? up_pay : lo_pay;

    o1_vld = up_to1 || lo_to1;
    o1_dst = up_to1 ? up_dst : lo_dst;
    o1_pay = up_to1 ? up_pay : lo_pay;
  end
endmodule

// File: rtl/bfly_stage.sv
`timescale 1ns/1ps
module bfly_stage
  import bfly_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int PAY_W  = 16,
  parameter int SLOT   = 0,
  localparam int NPORT = 1 << ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rev,
  input  logic [NPORT-1:0]        in_vld,
  input  logic [NPORT*ADDR_W-1:0] in_dst,
  input  logic [NPORT*PAY_W-1:0]  in_pay,
  output logic [NPORT-1:0]        out_vld,
  output logic [NPORT*ADDR_W-1:0] out_dst,
  output logic [NPORT*PAY_W-1:0]  out_pay
);
  localparam int NSW   = NPORT / 2;
  localparam int POS_F = route_pos(ADDR_W, SLOT, 1'b0);
  localparam int POS_R = route_pos(ADDR_W, SLOT, 1'b1);

  logic [NPORT-1:0]  sw_vld;
  logic [ADDR_W-1:0] sw_dst [NPORT];
  logic [PAY_W-1:0]  sw_pay [NPORT];

  logic [NPORT-1:0]  nxt_vld;
  logic [ADDR_W-1:0] nxt_dst [NPORT];
  logic [PAY_W-1:0]  nxt_pay [NPORT];

  logic [NPORT-1:0]  vld_q;
  logic [ADDR_W-1:0] dst_q [NPORT];
  logic [PAY_W-1:0]  pay_q [NPORT];

  // switch column
  for (genvar j = 0; j < NSW; j++) begin : g_sw
    localparam int PU = 2 * j;
    localparam int PL = 2 * j + 1;
    logic want_u, want_l;

    assign want_u = rev ? in_dst[PU*ADDR_W + POS_R] : in_dst[PU*ADDR_W + POS_F];
    assign want_l = rev ? in_dst[PL*ADDR_W + POS_R] : in_dst[PL*ADDR_W + POS_F];

    bfly_switch2 #(.ADDR_W(ADDR_W), .PAY_W(PAY_W)) u_sw (
      .up_vld (in_vld[PU]),
      .up_dst (in_dst[PU*ADDR_W +: ADDR_W]),
      .up_pay (in_pay[PU*PAY_W +: PAY_W]),
      .up_want(want_u),
      .lo_vld (in_vld[PL]),
      .lo_dst (in_dst[PL*ADDR_W +: ADDR_W]),
      .lo_pay (in_pay[PL*PAY_W +: PAY_W]),
      .lo_want(want_l),
      .o0_vld (sw_vld[PU]),
      .o0_dst (sw_dst[PU]),
      .o0_pay (sw_pay[PU]),
      .o1_vld (sw_vld[PL]),
      .o1_dst (sw_dst[PL]),
      .o1_pay (sw_pay[PL])
    );

    // R6: traffic must never ask one switch output twice
    p_no_collision_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld[PU] && in_vld[PL]) |-> (want_u != want_l));
  end

  // link wiring to the next column: exchange bit 0 with the decided position
  for (genvar p = 0; p < NPORT; p++) begin : g_link
    localparam int QF = swap_lsb(p, POS_F);
    localparam int QR = swap_lsb(p, POS_R);
    assign nxt_vld[p] = rev ? sw_vld[QR] : sw_vld[QF];
    assign nxt_dst[p] = rev ? sw_dst[QR] : sw_dst[QF];
    assign nxt_pay[p] = rev ? sw_pay[QR] : sw_pay[QF];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= nxt_vld;
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NPORT; p++) begin
      if (nxt_vld[p]) begin
        dst_q[p] <= nxt_dst[p];
        pay_q[p] <= nxt_pay[p];
      end
    end
  end

  always_comb begin
    out_vld = vld_q;
    for (int p = 0; p < NPORT; p++) begin
      out_dst[p*ADDR_W +: ADDR_W] = dst_q[p];
      out_pay[p*PAY_W +: PAY_W]   = pay_q[p];
    end
  end

  // R6: a column neither loses nor creates messages
  p_count_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(vld_q) == $countones($past(in_vld))));
endmodule

// File: rtl/bfly_dir_ctl.sv
`timescale 1ns/1ps
module bfly_dir_ctl
  import bfly_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dir_i,
  input  logic busy,
  output dir_e dir_now,
  output dir_e dir_held
);
  dir_e dir_q;

  // next state: follow the pin only while the network is empty
  always_comb begin
    dir_now = busy ? dir_q : dir_e'(dir_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= DIR_FWD;
    else        dir_q <= dir_now;
  end

  assign dir_held = dir_q;

  // R7: a held direction never moves while messages are inside
  p_dir_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (dir_q == $past(dir_q)));
endmodule

// File: rtl/bfly_router.sv
`timescale 1ns/1ps
module bfly_router
  import bfly_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int PAY_W  = 16,
  localparam int NPORT = 1 << ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dir_i,
  input  logic [NPORT-1:0]        in_vld,
  input  logic [NPORT*ADDR_W-1:0] in_dst,
  input  logic [NPORT*PAY_W-1:0]  in_pay,
  output logic [NPORT-1:0]        out_vld,
  output logic [NPORT*PAY_W-1:0]  out_pay
);
  logic rst_n_s;
  logic busy;
  dir_e dir_now, dir_held;

  logic [NPORT-1:0]        c_vld [ADDR_W+1];
  logic [NPORT*ADDR_W-1:0] c_dst [ADDR_W+1];
  logic [NPORT*PAY_W-1:0]  c_pay [ADDR_W+1];

  bfly_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_s)
  );

  always_comb begin
    busy = 1'b0;
    for (int k = 1; k <= ADDR_W; k++) busy = busy | (|c_vld[k]);
  end

  bfly_dir_ctl u_dir (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .dir_i   (dir_i),
    .busy    (busy),
    .dir_now (dir_now),
    .dir_held(dir_held)
  );

  assign c_vld[0] = in_vld;
  assign c_dst[0] = in_dst;
  assign c_pay[0] = in_pay;

  for (genvar k = 0; k < ADDR_W; k++) begin : g_col
    logic rev_k;
    // the entry slot may take a fresh direction; later slots use the held one
    if (k == 0) begin : g_head
      assign rev_k = (dir_now == DIR_REV);
    end else begin : g_body
      assign rev_k = (dir_held == DIR_REV);
    end

    bfly_stage #(.ADDR_W(ADDR_W), .PAY_W(PAY_W), .SLOT(k)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .rev    (rev_k),
      .in_vld (c_vld[k]),
      .in_dst (c_dst[k]),
      .in_pay (c_pay[k]),
      .out_vld(c_vld[k+1]),
      .out_dst(c_dst[k+1]),
      .out_pay(c_pay[k+1])
    );
  end

  assign out_vld = c_vld[ADDR_W];
  assign out_pay = c_pay[ADDR_W];

  // R3 / R4: a delivered message sits on the port its destination names
  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    p_dst_match_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
      out_vld[p] |-> (c_dst[ADDR_W][p*ADDR_W +: ADDR_W] == ADDR_W'(p)));
  end

  // R1: nothing is delivered on the first cycle out of reset
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> (out_vld == '0));
endmodule

// File: tb/sim_bfly_router.sv
`timescale 1ns/1ps
module sim_bfly_router;
  localparam int R = 3;
  localparam int W = 16;
  localparam int N = 1 << R;

  logic           clk;
  logic           rst_n;
  logic           dir_i;
  logic [N-1:0]   in_vld;
  logic [N*R-1:0] in_dst;
  logic [N*W-1:0] in_pay;
  logic [N-1:0]   out_vld;
  logic [N*W-1:0] out_pay;

  bfly_router #(.ADDR_W(R), .PAY_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .dir_i(dir_i),
    .in_vld(in_vld), .in_dst(in_dst), .in_pay(in_pay),
    .out_vld(out_vld), .out_pay(out_pay)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    int          due;
    int          port;
    logic [W-1:0] pay;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc   = 0;
  int   pay_seq = 1;
  bit   mon_on = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // routing rules taken from R3 / R4, used only to choose contention-free stimulus
  function automatic int col_pos(input int k, input bit rev);
    if (!rev) return R - 1 - k;
    if (k < R - 1) return k + 1;
    return 0;
  endfunction

  function automatic int xchg(input int a, input int pos);
    int b0, bp;
    b0 = a & 1;
    bp = (a >> pos) & 1;
    return (a & ~(1 | (1 << pos))) | (b0 << pos) | bp;
  endfunction

  function automatic bit clash(input int d[N], input logic [N-1:0] m, input bit rev);
    int a[N];
    bit used[N];
    for (int s = 0; s < N; s++) a[s] = s;
    for (int k = 0; k < R; k++) begin
      int pos;
      pos = col_pos(k, rev);
      for (int q = 0; q < N; q++) used[q] = 1'b0;
      for (int s = 0; s < N; s++) begin
        if (m[s]) begin
          int o;
          o = (a[s] & ~1) | ((d[s] >> pos) & 1);
          if (used[o]) return 1'b1;
          used[o] = 1'b1;
          a[s] = xchg(o, pos);
        end
      end
    end
    return 1'b0;
  endfunction

  task automatic pick(output int d[N], input logic [N-1:0] m, input bit rev, input bit need_other);
    bit ok;
    ok = 1'b0;
    for (int t = 0; t < 20000 && !ok; t++) begin
      for (int s = 0; s < N; s++) d[s] = s;
      for (int s = N - 1; s > 0; s--) begin
        int j, tmp;
        j = $urandom_range(s, 0);
        tmp = d[s]; d[s] = d[j]; d[j] = tmp;
      end
      ok = !clash(d, m, rev) && (!need_other || clash(d, m, !rev));
    end
    if (!ok) begin
      n_chk++; n_bad++;
      $display("FAIL R6 stimulus search: actual none found, expected a usable set");
    end
  endtask

  task automatic send(input int d[N], input logic [N-1:0] m, input bit pin, input string tag);
    @(negedge clk);
    dir_i = pin;
    for (int p = 0; p < N; p++) begin
      in_vld[p] = m[p];
      in_dst[p*R +: R] = d[p][R-1:0];
      in_pay[p*W +: W] = W'(pay_seq);
      if (m[p]) begin
        exp_t e;
        e.due = cyc + R; e.port = d[p]; e.pay = W'(pay_seq); e.tag = tag;
        sb.push_back(e);
      end
      pay_seq++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_vld = '0;
    end
  endtask

  // scoreboard monitor: R2 timing, R5 payload, R6 exactly-once
  always @(negedge clk) begin
    if (mon_on) begin
      for (int p = 0; p < N; p++) begin
        if (out_vld[p]) begin
          int hit;
          hit = -1;
          for (int i = 0; i < sb.size(); i++)
            if (hit < 0 && sb[i].due == cyc && sb[i].port == p) hit = i;
          n_chk++;
          if (hit < 0) begin
            n_bad++;
            $display("FAIL R2 port %0d cycle %0d: actual payload %0h, expected no delivery",
                     p, cyc, out_pay[p*W +: W]);
          end else begin
            if (out_pay[p*W +: W] !== sb[hit].pay) begin
              n_bad++;
              $display("FAIL R5 (%s) port %0d: actual payload %0h, expected %0h",
                       sb[hit].tag, p, out_pay[p*W +: W], sb[hit].pay);
            end
            sb.delete(hit);
          end
        end
      end
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].due <= cyc) begin
          n_chk++; n_bad++;
          $display("FAIL R6 (%s) port %0d: actual missing, expected payload %0h at cycle %0d",
                   sb[i].tag, sb[i].port, sb[i].pay, sb[i].due);
          sb.delete(i);
        end
      end
    end
  end

  task automatic finish_run;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout, expected completion");
      finish_run();
    end
  end

  initial begin
    int d[N];
    logic [N-1:0] m;

    rst_n = 1'b0; dir_i = 1'b0; in_vld = '0; in_dst = '0; in_pay = '0;
    repeat (3) begin
      @(negedge clk);
      n_chk++;
      if (out_vld !== '0) begin
        n_bad++;
        $display("FAIL R1 in reset: actual %b, expected 0", out_vld);
      end
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_chk++;
    if (out_vld !== '0) begin
      n_bad++;
      $display("FAIL R1 after reset: actual %b, expected 0", out_vld);
    end
    mon_on = 1'b1;

    // R2: single messages from every source, back to back, forward
    for (int s = 0; s < N; s++) begin
      for (int q = 0; q < N; q++) d[q] = 0;
      d[s] = $urandom_range(N - 1, 0);
      send(d, N'(1) << s, 1'b0, "R2");
    end
    idle(R + 2);

    // R3: full forward permutations, spaced
    for (int t = 0; t < 6; t++) begin
      pick(d, '1, 1'b0, 1'b0);
      send(d, '1, 1'b0, "R3");
      idle(2);
    end

    // R8: back-to-back full forward permutations
    for (int t = 0; t < 12; t++) begin
      pick(d, '1, 1'b0, 1'b0);
      send(d, '1, 1'b0, "R8");
    end

    // R6: partial loads, forward
    for (int t = 0; t < 8; t++) begin
      m = N'($urandom);
      pick(d, m, 1'b0, 1'b0);
      send(d, m, 1'b0, "R6");
    end
    idle(R + 2);

    // R7: direction taken while empty, first set only works in reverse
    pick(d, '1, 1'b1, 1'b1);
    send(d, '1, 1'b1, "R7");

    // R4: reverse permutations back to back
    for (int t = 0; t < 10; t++) begin
      pick(d, '1, 1'b1, 1'b0);
      send(d, '1, 1'b1, "R4");
    end

    // R7: pin flipped while busy is ignored; sets only work in reverse
    for (int t = 0; t < 4; t++) begin
      pick(d, '1, 1'b1, 1'b1);
      send(d, '1, 1'b0, "R7");
    end
    idle(R + 2);

    // R7: back to forward while empty, set only works forward
    pick(d, '1, 1'b0, 1'b1);
    send(d, '1, 1'b0, "R7");
    idle(R + 2);

    // R4: reverse partial loads
    for (int t = 0; t < 6; t++) begin
      m = N'($urandom);
      pick(d, m, 1'b1, 1'b0);
      send(d, m, 1'b1, "R4");
    end
    idle(R + 3);

    n_chk++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R6 leftover: actual %0d pending, expected 0", sb.size());
    end
    finish_run();
  end
endmodule